// File: doc/BRIEF.md
# XOR Bit-Permutation Network with Mask Alignment Tracking

This block moves a 256-bit value between three working registers (two data registers X and Y, and a mask register M) and a word of a small array memory. On the way, the bit order is permuted: output bit `i` takes input bit `i XOR f`, where `f` is an 8-bit effective flip value. Applying the same `f` a second time restores the original order, so a value stored with a flip address comes back in its natural order when read with the same address.

A HOME register records which flip the mask register currently carries. When M is the source, the flip applied is combined with HOME, so the mask can be realigned from one flipped word layout to another. HOME takes the address field whenever M is the destination and is left unchanged otherwise. The array memory is a plain register file with a separate external write port used to fill and update it. Each operation takes one clock: a `start` strobe launches it, and a `done` strobe one cycle later presents the permuted result, the effective flip and the new HOME value.

Top module: `xor_perm_unit`

## Requirements
- R1: When `done` is high, `result[i]` equals bit `i XOR eff_flip` of the selected source value, for all 256 positions; applying the same flip twice gives back the original value.
- R2: With `flip_en` = 0, the effective flip is 0 for sources X (code 0), Y (code 1) and memory (code 3), and equals the HOME value held before the operation for source M (code 2).
- R3: With `flip_en` = 1 and address field `b`, the effective flip is `b` for sources X, Y and memory, and HOME XOR `b` for source M.
- R4: When the destination is M (code 2), HOME becomes the address field; for any other destination HOME keeps its value.
- R5: After reset, `done` is 0, `home`, `eff_flip` and `result` are 0, and X, Y, M are all zeros.
- R6: `done` is high exactly in the cycle after each `start` cycle and at no other time; `result`, `eff_flip` and `home` are valid while `done` is high.
- R7: The destination register (X code 0, Y code 1, M code 2) holds the result after the operation, and the other registers are unchanged.
- R8: With destination memory (code 3) the result is written to the word indexed by the low bits of the address field; with source memory that word is read.
- R9: When an external write and an operation write target the same memory word in the same cycle, the operation's data remains; an operation reading a word in the same cycle as an external write to it sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches one operation this cycle |
| src_sel | input | 2 | Source: 0 X, 1 Y, 2 M, 3 memory |
| dst_sel | input | 2 | Destination: 0 X, 1 Y, 2 M, 3 memory |
| flip_en | input | 1 | Instruction flip enable |
| addr_fld | input | 8 | Address field: flip address and memory word index |
| arr_we | input | 1 | External memory write enable |
| arr_waddr | input | AW | External memory write word index |
| arr_wdata | input | 256 | External memory write data |
| done | output | 1 | Result valid strobe |
| result | output | 256 | Permuted value |
| home | output | 8 | HOME value after the operation |
| eff_flip | output | 8 | Effective flip value used |

## Verification
Two functions can meet in one cycle: an external fill of the array memory and an operation that reads or writes the same word, and an operation where M is both the source and the destination, so the old HOME feeds the flip while the new HOME is being loaded. The bench provokes the first by raising the external write with an operation aimed at the same word and at a different word, then reads both words back; the second by chaining M-to-M moves with different address fields. Its reference model applies the external write before the operation write and reads source data and HOME before any update, and each read-back is judged against that model.

// File: rtl/xor_perm_pkg.sv
package xor_perm_pkg;
  localparam int FLIP_W = 8;
  localparam int DATA_W = 1 << FLIP_W;

  typedef enum logic [1:0] {
    SEL_X   = 2'd0,
    SEL_Y   = 2'd1,
    SEL_M   = 2'd2,
    SEL_MEM = 2'd3
  } sel_e;

  // Effective flip: address field when enabled, folded with HOME for mask sources.
  function automatic logic [FLIP_W-1:0] calc_flip(
    input logic              fe,
    input logic              from_mask,
    input logic [FLIP_W-1:0] home_val,
    input logic [FLIP_W-1:0] addr_val
  );
    logic [FLIP_W-1:0] base;
    base = fe ? addr_val : '0;
    return from_mask ? (base ^ home_val) : base;
  endfunction
endpackage

// File: rtl/xor_perm_net.sv
module xor_perm_net #(
  parameter int FW = 8,
  localparam int DW = 1 << FW
) (
  input  logic [DW-1:0] din,
  input  logic [FW-1:0] flip,
  output logic [DW-1:0] dout
);
  for (genvar i = 0; i < DW; i++) begin : g_lane
    localparam logic [FW-1:0] LANE = FW'(i);
    assign dout[i] = din[LANE ^ flip];
  end

  // Involution: permuting the output again with the same flip restores din.
  logic [DW-1:0] dbg_back;
  for (genvar j = 0; j < DW; j++) begin : g_back
    localparam logic [FW-1:0] LANE_B = FW'(j);
    assign dbg_back[j] = dout[LANE_B ^ flip];
  end
  always_comb begin
    AST_PERM_INVOLUTION: assert (dbg_back == din); // R1
  end
endmodule

// File: rtl/home_track.sv
module home_track #(
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FW-1:0] addr_val,
  output logic [FW-1:0] home_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    home_q <= '0;
    else if (load) home_q <= addr_val;
  end

  AST_HOME_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> home_q == $past(addr_val)); // R4
  AST_HOME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(home_q)); // R4
endmodule

// File: rtl/arr_mem.sv
module arr_mem #(
  parameter int DW    = 256,
  parameter int WORDS = 16,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          ext_we,
  input  logic [AW-1:0] ext_addr,
  input  logic [DW-1:0] ext_data,
  input  logic          op_we,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] op_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem_q [WORDS];

  // Operation write is placed last so it overrides an external write to the same word.
  always_ff @(posedge clk) begin
    if (ext_we) mem_q[ext_addr] <= ext_data;
    if (op_we)  mem_q[op_addr]  <= op_data;
  end

  assign rd_data = mem_q[rd_addr];

  wire clash = ext_we && op_we && (ext_addr == op_addr);

  AST_OP_WINS: assert property (@(posedge clk)
    clash |=> mem_q[$past(op_addr)] == $past(op_data)); // R9
endmodule

// File: rtl/xor_perm_unit.sv
module xor_perm_unit #(
  parameter int MEM_WORDS = 16,
  localparam int FW = xor_perm_pkg::FLIP_W,
  localparam int DW = xor_perm_pkg::DATA_W,
  localparam int AW = $clog2(MEM_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    src_sel,
  input  logic [1:0]    dst_sel,
  input  logic          flip_en,
  input  logic [FW-1:0] addr_fld,
  input  logic          arr_we,
  input  logic [AW-1:0] arr_waddr,
  input  logic [DW-1:0] arr_wdata,
  output logic          done,
  output logic [DW-1:0] result,
  output logic [FW-1:0] home,
  output logic [FW-1:0] eff_flip
);
  import xor_perm_pkg::*;

  logic [DW-1:0] x_q, y_q, m_q;
  logic [DW-1:0] src_data, perm_data, mem_rd;
  logic [FW-1:0] home_cur, flip_now;
  logic          done_q;
  logic [DW-1:0] result_q;
  logic [FW-1:0] eff_q;

  wire src_is_m = (sel_e'(src_sel) == SEL_M);
  wire dst_is_m = (sel_e'(dst_sel) == SEL_M);
  wire op_fire  = start;
  wire home_ld  = op_fire && dst_is_m;
  wire mem_wr   = op_fire && (sel_e'(dst_sel) == SEL_MEM);
  wire [AW-1:0] word_idx = addr_fld[AW-1:0];

  always_comb begin
    case (sel_e'(src_sel))
      SEL_X:   src_data = x_q;
      SEL_Y:   src_data = y_q;
      SEL_M:   src_data = m_q;
      default: src_data = mem_rd;
    endcase
  end

  assign flip_now = calc_flip(flip_en, src_is_m, home_cur, addr_fld);

  xor_perm_net #(.FW(FW)) perm_i (
    .din  (src_data),
    .flip (flip_now),
    .dout (perm_data)
  );

  home_track #(.FW(FW)) home_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (home_ld),
    .addr_val (addr_fld),
    .home_q   (home_cur)
  );

  arr_mem #(.DW(DW), .WORDS(MEM_WORDS)) mem_i (
    .clk      (clk),
    .ext_we   (arr_we),
    .ext_addr (arr_waddr),
    .ext_data (arr_wdata),
    .op_we    (mem_wr),
    .op_addr  (word_idx),
    .op_data  (perm_data),
    .rd_addr  (word_idx),
    .rd_data  (mem_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q      <= '0;
      y_q      <= '0;
      m_q      <= '0;
      done_q   <= 1'b0;
      result_q <= '0;
      eff_q    <= '0;
    end else begin
      done_q <= op_fire;
      if (op_fire) begin
        result_q <= perm_data;
        eff_q    <= flip_now;
        case (sel_e'(dst_sel))
          SEL_X:   x_q <= perm_data;
          SEL_Y:   y_q <= perm_data;
          SEL_M:   m_q <= perm_data;
          default: ;
        endcase
      end
    end
  end

  assign done     = done_q;
  assign result   = result_q;
  assign home     = home_cur;
  assign eff_flip = eff_q;

  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done); // R6
  AST_DONE_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done); // R6
  AST_EFF_PLAIN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !flip_en && !src_is_m) |=> eff_flip == '0); // R2
  AST_EFF_PLAIN_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (start && flip_en && !src_is_m) |=> eff_flip == $past(addr_fld)); // R3
  AST_EFF_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (start && src_is_m) |=> eff_flip == ($past(home) ^ ($past(flip_en) ? $past(addr_fld) : '0))); // R3
  AST_MASK_DST: assert property (@(posedge clk) disable iff (!rst_n)
    (start && dst_is_m) |=> m_q == result); // R7
endmodule

// File: tb/xor_perm_unit_tb_top.sv
module xor_perm_unit_tb_top;
  localparam int WORDS = 16;
  localparam int AW    = $clog2(WORDS);

  typedef struct {
    logic [255:0] res;
    logic [7:0]   eff;
    logic [7:0]   hm;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   src_sel = '0, dst_sel = '0;
  logic         flip_en = 1'b0;
  logic [7:0]   addr_fld = '0;
  logic         arr_we = 1'b0;
  logic [AW-1:0] arr_waddr = '0;
  logic [255:0] arr_wdata = '0;
  logic         done;
  logic [255:0] result;
  logic [7:0]   home, eff_flip;

  int n_cmp = 0, n_bad = 0;
  exp_t sb_q[$];

  logic [255:0] mx = '0, my = '0, mm = '0;
  logic [7:0]   mhome = '0;
  logic [255:0] mmem [WORDS];

  always #10 clk = ~clk;

  xor_perm_unit #(.MEM_WORDS(WORDS)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .src_sel(src_sel), .dst_sel(dst_sel),
    .flip_en(flip_en), .addr_fld(addr_fld), .arr_we(arr_we), .arr_waddr(arr_waddr),
    .arr_wdata(arr_wdata), .done(done), .result(result), .home(home), .eff_flip(eff_flip)
  );

  function automatic logic [255:0] scatter(input logic [255:0] v, input logic [7:0] f);
    logic [255:0] o;
    for (int j = 0; j < 256; j++) o[j ^ int'(f)] = v[j];
    return o;
  endfunction

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic ext_write(input logic [AW-1:0] wa, input logic [255:0] wd);
    @(negedge clk);
    arr_we = 1'b1; arr_waddr = wa; arr_wdata = wd;
    mmem[wa] = wd;
    @(negedge clk);
    arr_we = 1'b0;
  endtask

  task automatic issue(input logic [1:0] s, input logic [1:0] d, input logic fe,
                       input logic [7:0] a, input logic we, input logic [AW-1:0] wa,
                       input logic [255:0] wd, input string tag);
    logic [255:0] sv, r;
    logic [7:0]   f;
    exp_t e;
    @(negedge clk);
    case (s)
      2'd0: sv = mx;
      2'd1: sv = my;
      2'd2: sv = mm;
      default: sv = mmem[a[AW-1:0]];
    endcase
    f = fe ? a : 8'h00;
    if (s == 2'd2) f = f ^ mhome;
    r = scatter(sv, f);
    if (we) mmem[wa] = wd;
    case (d)
      2'd0: mx = r;
      2'd1: my = r;
      2'd2: begin mm = r; mhome = a; end
      default: mmem[a[AW-1:0]] = r;
    endcase
    e.res = r; e.eff = f; e.hm = mhome; e.tag = tag;
    sb_q.push_back(e);
    start = 1'b1; src_sel = s; dst_sel = d; flip_en = fe; addr_fld = a;
    arr_we = we; arr_waddr = wa; arr_wdata = wd;
    @(negedge clk);
    start = 1'b0; arr_we = 1'b0;
  endtask

  task automatic op(input logic [1:0] s, input logic [1:0] d, input logic fe,
                    input logic [7:0] a, input string tag);
    issue(s, d, fe, a, 1'b0, '0, '0, tag);
  endtask

  // Monitor: pops the scoreboard whenever the design signals a result.
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R6: actual done=1 expected done=0");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check({e.tag, " result"}, result, e.res);
        check({e.tag, " eff_flip (R2/R3)"}, 256'(eff_flip), 256'(e.eff));
        check({e.tag, " home (R4)"}, 256'(home), 256'(e.hm));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  logic [255:0] pat_a, pat_b;

  initial begin
    for (int k = 0; k < WORDS; k++) mmem[k] = '0;
    repeat (3) @(negedge clk);
    check("R5 done", 256'(done), 256'(0));
    check("R5 home", 256'(home), 256'(0));
    check("R5 eff_flip", 256'(eff_flip), 256'(0));
    check("R5 result", result, '0);
    rst_n = 1'b1;
    // R5: M reset to zeros, HOME 0 so eff 0
    op(2'd2, 2'd0, 1'b0, 8'h00, "R5 mask zero");
    pat_a = {8{32'hDEADBEEF}} ^ {256'(1) << 3};
    pat_b = {16{16'h1234}} ^ (256'(1) << 255);
    for (int k = 0; k < WORDS; k++) ext_write(AW'(k), {8{$urandom}});
    ext_write(AW'(0), pat_a);
    ext_write(AW'(1), pat_b);
    op(2'd3, 2'd0, 1'b0, 8'h00, "R8 mem to X plain");
    op(2'd3, 2'd1, 1'b1, 8'h01, "R1 R3 mem to Y flip 1");
    op(2'd0, 2'd0, 1'b1, 8'd10, "R1 X flip 10");
    op(2'd0, 2'd0, 1'b1, 8'd10, "R1 X flip 10 again restores");
    check("R7 X restored", mx, pat_a);
    op(2'd1, 2'd1, 1'b0, 8'hFF, "R2 Y plain ignores addr");
    op(2'd0, 2'd2, 1'b1, 8'd20, "R4 X to M home 20");
    op(2'd2, 2'd0, 1'b0, 8'h33, "R2 M source uses HOME");
    op(2'd2, 2'd2, 1'b1, 8'd21, "R3 R4 M to M realign");
    op(2'd2, 2'd2, 1'b1, 8'hA5, "R3 R4 M to M again");
    op(2'd2, 2'd3, 1'b1, 8'h07, "R8 M to mem");
    op(2'd3, 2'd1, 1'b0, 8'h07, "R8 R7 read back word 7");
    op(2'd0, 2'd1, 1'b1, 8'hFF, "R1 flip FF");
    // R9: same word collision, op write wins
    issue(2'd0, 2'd3, 1'b1, 8'h05, 1'b1, AW'(5), {8{32'hCAFEF00D}}, "R9 op write wins");
    op(2'd3, 2'd0, 1'b0, 8'h05, "R9 read word 5");
    // R9: different words both land
    issue(2'd1, 2'd3, 1'b0, 8'h06, 1'b1, AW'(9), {8{32'h0BADC0DE}}, "R9 both writes");
    op(2'd3, 2'd0, 1'b0, 8'h09, "R9 read word 9");
    op(2'd3, 2'd1, 1'b0, 8'h06, "R9 read word 6");
    // R9: read sees old contents during external write
    issue(2'd3, 2'd0, 1'b0, 8'h02, 1'b1, AW'(2), {8{32'h55AA55AA}}, "R9 read old word 2");
    op(2'd3, 2'd1, 1'b0, 8'h02, "R9 read new word 2");
    for (int k = 0; k < 60; k++) begin
      logic [1:0] s, d;
      s = 2'($urandom); d = 2'($urandom);
      issue(s, d, 1'($urandom), 8'($urandom), 1'($urandom), AW'($urandom),
            {8{$urandom}}, "R1 R7 random");
    end
    repeat (3) @(negedge clk);
    check("R6 all results seen", 256'(sb_q.size()), 256'(0));
    check("R6 done idle", 256'(done), 256'(0));
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule